// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus slave that sits in front of a small internal byte store. It runs entirely on the system clock. It resynchronises the bus clock and data lines, finds start and stop conditions, and decodes a device byte and a two-byte word address. The data line is driven through an open-drain enable, where a high output pulls the wire low. The store size is a parameter.

One shared pointer serves all transfers. A read moves it through the whole store and wraps from the top address to zero. A write moves it only inside the current page, so a long write folds back onto the start of that page. A write-addressed transfer that stops straight after the word address only reloads the pointer. A following read with no address then starts from the loaded location.

A read-addressed transfer returns bytes MSB first. The master acknowledges each byte to get the next one. It sends a not-acknowledge, or a stop during the acknowledge clock, to end the transfer.

Top module: `ee_i2c_slave`

## Requirements
- R1: While reset is held low, `sda_oe` is 0. After reset the shared pointer is 0, so a read with no address returns the byte at location 0. Reset does not clear the stored bytes.
- R2: The device byte is bits 7..4 = 1010, bits 3..1 equal to `sel_i`, and bit 0 = R/W, where 1 means read. On a match the slave pulls SDA low in the ninth clock. On any mismatch it does not acknowledge, and it ignores every later byte until the next start.
- R3: A write-addressed transfer carries the high word-address byte and then the low one, and the slave acknowledges each. After a repeated start and a read-addressed device byte, the slave returns the byte stored at that address. Word-address bits above log2(DEPTH) are ignored.
- R4: In a read, each master acknowledge makes the slave send the byte at the next address. After the last location, the next byte comes from location 0.
- R5: Data bytes that follow the word address are stored at consecutive addresses. Each is acknowledged. Stepping past the last byte of a PAGE-sized page returns to the first byte of that same page.
- R6: After any transfer, the pointer holds the address of the last byte read or written plus one, with the wrap rule of that transfer. A read with no address returns the byte at the pointer.
- R7: If a stop follows the low word-address byte, the address is loaded into the pointer and no stored byte changes.
- R8: A master not-acknowledge ends the output. The slave releases SDA and ignores further clocks until a stop or a start. After a stop it drives nothing until the next start.
- R9: Data bits leave MSB first, and `sda_oe` changes only while SCL is low.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point, including a repeated start, begins a new device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sel_i | input | 3 | Strap value matched against device-byte bits 3..1 |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The assertions assume the master moves SDA only while SCL is low, except for start and stop. They also assume SCL stays low for several system clocks after each falling edge, longer than the synchroniser delay. Under those two conditions a change of `sda_oe` always lands in a low SCL phase. The bench's master tasks hold every SCL phase for eight system clocks. They change SDA only two clocks into a low phase, or deliberately while SCL is high to form a start or a stop. Because the wire model ANDs the master's level with the slave's release, acknowledge bits and read data are observed exactly as a real bus would show them.

// File: rtl/ee_pkg.sv
// Shared types for the two-wire memory slave.
// Assumes an 8-bit data path and a 3-bit strap select.
package ee_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         DATA_W   = 8;

    // Protocol position of the slave
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } ee_state_t;

    // Action on the shared address pointer in one cycle
    typedef enum logic [1:0] {
        PTR_KEEP,
        PTR_LOAD,
        PTR_RD_INC,
        PTR_WR_INC
    } ee_ptr_op_t;

endpackage

// File: rtl/ee_bus_sync.sv
// Bus line conditioner: two-flop synchronisers on SCL and SDA, plus
// one delayed copy of each for edge and bus-condition detection.
// Assumes both lines idle high; reset preloads the flops high so no
// spurious condition is seen when reset is released.
module ee_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;
    logic       scl_s;

    // Resynchronise the lines and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    // Decode clock edges and start/stop from synchronised samples
    always_comb begin
        scl_s     = scl_ff[1];
        sda_s     = sda_ff[1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/ee_addr_ptr.sv
// Shared address pointer. It loads a new address, steps across the whole
// array for reads, or steps inside the current page for writes.
// Assumes PAGE is a power of two no larger than the array.
module ee_addr_ptr
    import ee_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ee_ptr_op_t        op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'(PAGE - 1);

    logic [ADDR_W-1:0] step;

    // Next address before any page folding
    always_comb step = ptr + 1'b1;

    // Apply the requested pointer action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                PTR_LOAD:   ptr <= load_val;
                PTR_RD_INC: ptr <= step;
                PTR_WR_INC: ptr <= (ptr & ~PG_MASK) | (step & PG_MASK);
                default:    ptr <= ptr;
            endcase
        end
    end

endmodule

// File: rtl/ee_byte_array.sv
// Byte store with one synchronous write port and one combinational
// read port. Contents are not reset. Assumes DEPTH is a power of two.
module ee_byte_array #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte when the write strobe is set
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the byte at the pointer
    always_comb rdata = mem[addr];

endmodule

// File: rtl/ee_i2c_slave.sv
// Two-wire serial memory slave. It decodes the device byte and the
// two-byte word address, then serves reads, sequential reads, page
// writes and pointer loads through one shared pointer.
// Assumes an open-drain pad outside: sda_oe = 1 pulls the wire low, and
// sda_i returns the wired level. DEPTH and PAGE are powers of two, with
// PAGE <= DEPTH <= 65536.
module ee_i2c_slave
    import ee_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PAGE  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    output logic       sda_oe
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;

    ee_state_t         state;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic [7:0]        hi_byte;
    logic              rw;
    logic              m_ack;
    logic              oe_q;

    ee_ptr_op_t        ptr_op;
    logic              mem_we;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] load_val;
    logic [7:0]        rdata;
    logic              quiet;
    logic              byte_end;

    ee_bus_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ee_addr_ptr #(
        .ADDR_W (ADDR_W),
        .PAGE   (PAGE)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ptr_op),
        .load_val (load_val),
        .ptr      (ptr_q)
    );

    ee_byte_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr_q),
        .wdata (shreg),
        .rdata (rdata)
    );

    // Word address assembled from both bytes, upper bits dropped
    always_comb load_val = ADDR_W'({hi_byte, shreg});

    // Pointer and write strobes for the current cycle
    always_comb begin
        quiet    = !start_det && !stop_det;
        byte_end = quiet && scl_fall && (bit_cnt == 4'd8);
        ptr_op   = PTR_KEEP;
        mem_we   = 1'b0;
        if (byte_end && state == ST_ALO) begin
            ptr_op = PTR_LOAD;
        end else if (byte_end && state == ST_WR) begin
            ptr_op = PTR_WR_INC;
            mem_we = 1'b1;
        end else if (quiet && scl_fall && state == ST_DEV_ACK && rw) begin
            ptr_op = PTR_RD_INC;
        end else if (quiet && scl_fall && state == ST_RD_ACK && m_ack) begin
            ptr_op = PTR_RD_INC;
        end
    end

    // Protocol sequencer: bit counting, acknowledge and data drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            hi_byte <= '0;
            rw      <= 1'b0;
            m_ack   <= 1'b0;
            oe_q    <= 1'b0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV) begin
                            if (shreg[7:4] == DEV_TYPE && shreg[3:1] == sel_i) begin
                                rw    <= shreg[0];
                                oe_q  <= 1'b1;
                                state <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_AHI) begin
                            hi_byte <= shreg;
                            oe_q    <= 1'b1;
                            state   <= ST_AHI_ACK;
                        end else if (state == ST_ALO) begin
                            oe_q  <= 1'b1;
                            state <= ST_ALO_ACK;
                        end else begin
                            oe_q  <= 1'b1;
                            state <= ST_WR_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            txreg   <= rdata;
                            oe_q    <= ~rdata[7];
                            bit_cnt <= 4'd1;
                            state   <= ST_RD;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_AHI;
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        oe_q  <= 1'b0;
                        state <= ST_ALO;
                    end
                end
                ST_ALO_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        oe_q  <= 1'b0;
                        state <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            oe_q  <= 1'b0;
                            state <= ST_RD_ACK;
                        end else begin
                            oe_q    <= ~txreg[6];
                            txreg   <= {txreg[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            txreg   <= rdata;
                            oe_q    <= ~rdata[7];
                            bit_cnt <= 4'd1;
                            state   <= ST_RD;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_HOLD;
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    // Drive the open-drain enable from its register
    always_comb sda_oe = oe_q;

endmodule

// File: rtl/ee_i2c_slave_chk.sv
// Property checker for the two-wire memory slave, bound to the top.
// Assumes the master changes SDA only in low SCL phases except for
// start/stop, and holds SCL low longer than the synchroniser delay.
module ee_i2c_slave_chk
    import ee_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr,
    input ee_ptr_op_t        ptr_op
);

    localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'(PAGE - 1);

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R8

    AST_RELEASE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R10

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R9

    AST_WRITE_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ((ptr & HI_MASK) == ($past(ptr) & HI_MASK))); // R5

    AST_READ_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == PTR_RD_INC && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0)); // R4

endmodule

bind ee_i2c_slave ee_i2c_slave_chk #(
    .ADDR_W (ADDR_W),
    .PAGE   (PAGE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_we    (mem_we),
    .ptr       (ptr_q),
    .ptr_op    (ptr_op)
);

// File: tb/ee_i2c_slave_bench.sv
`timescale 1ns/1ps
module ee_i2c_slave_bench;

    localparam int         HP  = 8;
    localparam logic [2:0] SEL = 3'b101;
    // Table entry: write address, read-back address, data byte
    localparam logic [39:0] VEC [6] = '{
        {16'h0000, 16'h0000, 8'hA5},
        {16'h00FF, 16'h00FF, 8'h3C},
        {16'h0041, 16'h0041, 8'h5A},
        {16'h0010, 16'h0010, 8'h77},
        {16'hFF05, 16'h0005, 8'hC3},
        {16'h0080, 16'h0080, 8'h96}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   tests = 0;
    int   fails = 0;
    int   oe_high_viol = 0;
    logic oe_seen = 1'b0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    ee_i2c_slave u_ee_i2c_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sel_i  (SEL),
        .sda_oe (sda_oe)
    );

    // Watch for drive changes during high SCL, and any drive at all (R9, R8)
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) oe_high_viol++;
        if (sda_oe) oe_seen <= 1'b1;
        oe_prev <= sda_oe;
    end

    task automatic tick(); repeat (HP) @(negedge clk); endtask
    task automatic hold(); repeat (2) @(negedge clk); endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); sda_m = 1'b0; tick(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1; tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(); scl_m = 1'b1; tick(); scl_m = 1'b0; hold();
        end
        sda_m = 1'b1; tick(); scl_m = 1'b1; tick();
        acked = !sda_bus;
        scl_m = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(); scl_m = 1'b1; tick(); b = {b[6:0], sda_bus}; scl_m = 1'b0; hold();
        end
        sda_m = !ack; tick(); scl_m = 1'b1; tick(); scl_m = 1'b0; hold();
    endtask

    task automatic set_addr(input logic [15:0] a, output logic acked);
        logic k1, k2, k3;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, k1);
        send_byte(a[15:8], k2);
        send_byte(a[7:0], k3);
        acked = k1 & k2 & k3;
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] d, output logic acked);
        logic k1, k2;
        set_addr(a, k1);
        send_byte(d, k2);
        bus_stop();
        acked = k1 & k2;
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
        logic k;
        set_addr(a, k);
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic k;
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        logic [7:0] rd;
        logic       ak;
        // Reset state (R1)
        repeat (10) @(negedge clk);
        chk("R1 oe in reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: byte write then random read with repeated start (R3 R10)
        for (int i = 0; i < 6; i++) begin
            write_one(VEC[i][39:24], VEC[i][7:0], ak);
            chk("R2 R5 write acked", {7'd0, ak}, 8'h01);
            rand_read(VEC[i][23:8], rd);
            chk("R3 R10 random read", rd, VEC[i][7:0]);
        end

        // Pointer back to 0 after reset, contents kept (R1)
        rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
        cur_read(rd);
        chk("R1 read after reset", rd, 8'hA5);

        // Wrong strap and wrong type code are not acknowledged (R2)
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ak);
        chk("R2 strap mismatch ack", {7'd0, ak}, 8'h00);
        send_byte(8'h00, ak); send_byte(8'h10, ak); send_byte(8'hEE, ak);
        bus_stop();
        rand_read(16'h0010, rd);
        chk("R2 ignored bytes not stored", rd, 8'h77);
        bus_start();
        send_byte({4'b1011, SEL, 1'b1}, ak);
        bus_stop();
        chk("R2 type mismatch ack", {7'd0, ak}, 8'h00);

        // Sequential read across the top of the array (R4)
        set_addr(16'h00FF, ak);
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ak);
        recv_byte(1'b1, rd);
        chk("R4 seq first", rd, 8'h3C);
        recv_byte(1'b0, rd);
        bus_stop();
        chk("R4 seq wrap to 0", rd, 8'hA5);

        // Page write folding back inside a 64-byte page (R5), pointer after (R6)
        set_addr(16'h007E, ak);
        send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak);
        bus_stop();
        cur_read(rd);
        chk("R6 pointer after page write", rd, 8'h5A);
        rand_read(16'h0040, rd);
        chk("R5 page fold", rd, 8'h33);
        rand_read(16'h007E, rd);
        chk("R5 first of page write", rd, 8'h11);
        rand_read(16'h007F, rd);
        chk("R5 last of page", rd, 8'h22);
        cur_read(rd);
        chk("R6 pointer after read", rd, 8'h96);

        // Pointer load with stop after the word address (R7)
        set_addr(16'h0005, ak);
        bus_stop();
        cur_read(rd);
        chk("R7 set current address", rd, 8'hC3);

        // NACK ends output; later clocks and post-stop bytes see no drive (R8)
        set_addr(16'h0000, ak);
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ak);
        recv_byte(1'b0, rd);
        oe_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            tick(); scl_m = 1'b1; tick(); scl_m = 1'b0; hold();
        end
        chk("R8 no drive after nack", {7'd0, oe_seen}, 8'h00);
        bus_stop();
        oe_seen = 1'b0;
        sda_m = 1'b0; tick();
        for (int i = 0; i < 9; i++) begin
            scl_m = 1'b1; tick(); scl_m = 1'b0; hold();
        end
        sda_m = 1'b1; tick();
        chk("R8 idle after stop", {7'd0, oe_seen}, 8'h00);

        // Drive changes only while SCL low (R9)
        chk("R9 oe change in high SCL", oe_high_viol[7:0], 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule